// File: doc/BRIEF.md
# Brown-out and Power-up Reset Sequencer

This block produces the chip-wide internal reset. It merges three causes of reset: a power-on indication, the digital output of a supply comparator that reports a low supply, and reset requests from other logic such as a watchdog. All of its logic runs on a slow free-running clock. The power-on and comparator inputs are asynchronous, so each passes through a two-flop synchronizer before any other logic uses it.

A low indication from the comparator counts as a brown-out only after it has lasted a set number of consecutive clock cycles while the detector is enabled. Shorter dips are filtered out. A two-bit mode field enables the detector in one of four ways: never, under a software enable bit, only while the device is awake, or always. When all reset causes have cleared, the sequencer releases reset. Before release it can run an optional power-up delay of a set number of clock ticks. If a brown-out occurs during that delay, the count starts again from zero. Two sticky active-low status flags record whether the last reset came from power-on or from brown-out. Software sets each flag back to 1 by writing to it.

Top module: `brownout_reset_seq`

## Requirements
- R1: `rst_out` is 1 while `por_in` is 1 and in the cycle after any edge that samples `ext_rst_req` = 1. The power-on input reaches the sequencer through two synchronizer flops.
- R2: With `pwrt_off` = 0, after the last reset cause clears, `rst_out` stays 1 for exactly `PWRT_TICKS` more cycles. If `ext_rst_req` is last sampled 0 at edge k, `rst_out` falls at edge k+`PWRT_TICKS`. If `por_in` falls before edge 1, `rst_out` falls at edge `PWRT_TICKS`+3.
- R3: With `pwrt_off` = 1, the delay is skipped. `rst_out` falls at edge k after `ext_rst_req` clears, and at edge 3 after `por_in` falls.
- R4: A brown-out trips once the synchronized comparator low has been seen on `BOD_QUAL` consecutive edges with the detector enabled. A low level seen on only `BOD_QUAL`-1 edges never asserts `rst_out`.
- R5: `bod_mode` = 2'b00 keeps the detector disabled. A comparator low of any length produces no reset.
- R6: `bod_mode` = 2'b01 enables the detector exactly when `sw_bod_en` = 1.
- R7: `bod_mode` = 2'b10 enables the detector when `sleep_mode` = 0 and disables it when `sleep_mode` = 1. In this mode `sw_bod_en` has no effect.
- R8: `bod_mode` = 2'b11 enables the detector regardless of `sleep_mode` and `sw_bod_en`.
- R9: Each cycle the detector is disabled clears the qualification count. A long low that is broken by a disabled cycle at least once every `BOD_QUAL`-2 enabled cycles never trips.
- R10: `rst_out` stays 1 while a brown-out is tripped. When the comparator clears, a full delay runs: `rst_out` falls at edge `PWRT_TICKS`+4 after `bod_low_in` falls. A brown-out during the delay restarts it, and `rst_out` never falls in between.
- R11: Power-on leaves `por_flag_n` = 0 and `bod_flag_n` = 1. A brown-out trip clears `bod_flag_n` and leaves `por_flag_n` unchanged. A one-cycle pulse on `por_flag_wr` or `bod_flag_wr` sets the matching flag to 1. An external reset changes neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Slow low-frequency clock |
| por_in | input | 1 | Asynchronous power-on indication, active high |
| bod_low_in | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| ext_rst_req | input | 1 | Synchronous reset request (watchdog and others), active high |
| pwrt_off | input | 1 | Configuration: 1 skips the power-up delay |
| bod_mode | input | 2 | Configuration: detector enable mode |
| sw_bod_en | input | 1 | Software detector enable, used in mode 2'b01 |
| sleep_mode | input | 1 | 1 while the device sleeps |
| por_flag_wr | input | 1 | Write pulse that sets `por_flag_n` |
| bod_flag_wr | input | 1 | Write pulse that sets `bod_flag_n` |
| rst_out | output | 1 | Internal reset, active high |
| por_flag_n | output | 1 | Sticky flag, 0 = power-on occurred |
| bod_flag_n | output | 1 | Sticky flag, 0 = brown-out occurred |

## Verification
The bench builds the block with `PWRT_TICKS` = 20 and `BOD_QUAL` = 5. With these values the exact release edge after each reset cause can be counted in a few dozen cycles instead of about two thousand. The bench can also place dips exactly at `BOD_QUAL`-1 and `BOD_QUAL` edges to test the filter boundary. The short delay also lets a brown-out be inserted halfway through a running delay, so the restart and the flag behaviour are observed many times within a short run.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    BODM_OFF   = 2'b00,
    BODM_SW    = 2'b01,
    BODM_AWAKE = 2'b10,
    BODM_ON    = 2'b11
  } bod_mode_e;

  // Detector enable as a function of mode, software bit and sleep state.
  function automatic logic det_enable(logic [1:0] mode, logic sw_en, logic asleep);
    logic en;
    case (bod_mode_e'(mode))
      BODM_OFF:   en = 1'b0;
      BODM_SW:    en = sw_en;
      BODM_AWAKE: en = ~asleep;
      default:    en = 1'b1;
    endcase
    return en;
  endfunction

endpackage

// File: rtl/brs_sync2.sv
module brs_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stage_q <= {2{RST_VAL}};
    else      stage_q <= {stage_q[0], d};
  end

  assign q = stage_q[1];
endmodule

// File: rtl/brs_bod_qual.sv
module brs_bod_qual #(
  parameter int unsigned QUAL_LEN = 3
) (
  input  logic clk,
  input  logic arst,
  input  logic det_en,
  input  logic low,
  output logic trip
);
  localparam int unsigned QW = $clog2(QUAL_LEN + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_LEN);

  logic [QW-1:0] qcnt_q;

  // Consecutive-cycle counter; any disabled or high-supply cycle clears it.
  always_ff @(posedge clk or posedge arst) begin
    if (arst)                 qcnt_q <= '0;
    else if (!det_en || !low) qcnt_q <= '0;
    else if (qcnt_q != QMAX)  qcnt_q <= qcnt_q + 1'b1;
  end

  assign trip = (qcnt_q == QMAX);
endmodule

// File: rtl/brs_seq.sv
module brs_seq
  import brs_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 1984,
  parameter int unsigned CW = $clog2(PWRT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          src_active,
  input  logic          pwrt_off,
  output logic          rst,
  output logic          delay_done,
  output logic          skip_go,
  output logic [CW-1:0] delay_cnt
);
  localparam logic [CW-1:0] TERM = CW'(PWRT_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q;

  assign delay_done = (state_q == SEQ_DELAY) && (cnt_q == TERM);
  assign skip_go    = (state_q == SEQ_HOLD) && !src_active && pwrt_off;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (src_active) begin
      state_d = SEQ_HOLD;
      cnt_d   = '0;
    end else begin
      case (state_q)
        SEQ_HOLD: begin
          cnt_d   = '0;
          state_d = pwrt_off ? SEQ_RUN : SEQ_DELAY;
        end
        SEQ_DELAY: begin
          if (delay_done) begin
            state_d = SEQ_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rst_q   <= (state_d != SEQ_RUN);
    end
  end

  assign rst       = rst_q;
  assign delay_cnt = cnt_q;
endmodule

// File: rtl/brs_flags.sv
module brs_flags (
  input  logic clk,
  input  logic arst,
  input  logic por_evt,
  input  logic bod_evt,
  input  logic por_wr,
  input  logic bod_wr,
  output logic por_n,
  output logic bod_n
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      por_n <= 1'b0;
      bod_n <= 1'b1;
    end else begin
      if (por_evt)     por_n <= 1'b0;
      else if (por_wr) por_n <= 1'b1;
      if (bod_evt)     bod_n <= 1'b0;
      else if (bod_wr) bod_n <= 1'b1;
    end
  end
endmodule

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq
  import brs_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 1984,
  parameter int unsigned BOD_QUAL   = 3
) (
  input  logic       clk_lf,
  input  logic       por_in,
  input  logic       bod_low_in,
  input  logic       ext_rst_req,
  input  logic       pwrt_off,
  input  logic [1:0] bod_mode,
  input  logic       sw_bod_en,
  input  logic       sleep_mode,
  input  logic       por_flag_wr,
  input  logic       bod_flag_wr,
  output logic       rst_out,
  output logic       por_flag_n,
  output logic       bod_flag_n
);
  localparam int unsigned CNT_W = $clog2(PWRT_TICKS + 1);

  // Named internal events, also observed by the bound checker.
  logic             por_sync;
  logic             bod_sync;
  logic             det_en;
  logic             bod_trip;
  logic             src_active;
  logic             delay_done;
  logic             skip_go;
  logic [CNT_W-1:0] delay_cnt;

  brs_sync2 #(.RST_VAL(1'b1)) u_por_sync (
    .clk(clk_lf), .arst(por_in), .d(1'b0), .q(por_sync)
  );

  brs_sync2 #(.RST_VAL(1'b0)) u_bod_sync (
    .clk(clk_lf), .arst(por_in), .d(bod_low_in), .q(bod_sync)
  );

  assign det_en = det_enable(bod_mode, sw_bod_en, sleep_mode);

  brs_bod_qual #(.QUAL_LEN(BOD_QUAL)) u_qual (
    .clk(clk_lf), .arst(por_in), .det_en(det_en), .low(bod_sync), .trip(bod_trip)
  );

  assign src_active = por_sync | ext_rst_req | bod_trip;

  brs_seq #(.PWRT_TICKS(PWRT_TICKS), .CW(CNT_W)) u_seq (
    .clk(clk_lf), .arst(por_in), .src_active(src_active), .pwrt_off(pwrt_off),
    .rst(rst_out), .delay_done(delay_done), .skip_go(skip_go), .delay_cnt(delay_cnt)
  );

  brs_flags u_flags (
    .clk(clk_lf), .arst(por_in), .por_evt(por_sync), .bod_evt(bod_trip),
    .por_wr(por_flag_wr), .bod_wr(bod_flag_wr),
    .por_n(por_flag_n), .bod_n(bod_flag_n)
  );
endmodule

// File: rtl/brownout_reset_seq_chk.sv
module brownout_reset_seq_chk #(
  parameter int unsigned PWRT_TICKS = 1984,
  parameter int unsigned CW = 11
) (
  input logic          clk,
  input logic          por_in,
  input logic          por_sync,
  input logic          ext_req,
  input logic          det_en,
  input logic          bod_trip,
  input logic          rst_out,
  input logic          delay_done,
  input logic          skip_go,
  input logic [CW-1:0] delay_cnt,
  input logic          por_flag_n,
  input logic          bod_flag_n
);
  localparam logic [CW-1:0] TERM = CW'(PWRT_TICKS - 1);

  p_por_resets_r1: assert property (@(posedge clk) disable iff (por_in)
    por_sync |=> rst_out);

  p_ext_resets_r1: assert property (@(posedge clk) disable iff (por_in)
    ext_req |=> rst_out);

  // Release only at terminal count or on a skipped delay (R3).
  p_release_r2: assert property (@(posedge clk) disable iff (por_in)
    $fell(rst_out) |-> $past(delay_done || skip_go));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (por_in)
    delay_cnt <= TERM);

  p_trip_resets_r4: assert property (@(posedge clk) disable iff (por_in)
    bod_trip |=> rst_out);

  p_disabled_no_trip_r9: assert property (@(posedge clk) disable iff (por_in)
    !det_en |=> !bod_trip);

  p_restart_r10: assert property (@(posedge clk) disable iff (por_in)
    bod_trip |=> (delay_cnt == '0));

  p_bod_flag_r11: assert property (@(posedge clk) disable iff (por_in)
    bod_trip |=> !bod_flag_n);

  p_por_flag_r11: assert property (@(posedge clk) disable iff (por_in)
    por_sync |=> !por_flag_n);
endmodule

bind brownout_reset_seq brownout_reset_seq_chk #(
  .PWRT_TICKS(PWRT_TICKS), .CW(CNT_W)
) u_chk (
  .clk(clk_lf), .por_in(por_in), .por_sync(por_sync), .ext_req(ext_rst_req),
  .det_en(det_en), .bod_trip(bod_trip), .rst_out(rst_out),
  .delay_done(delay_done), .skip_go(skip_go), .delay_cnt(delay_cnt),
  .por_flag_n(por_flag_n), .bod_flag_n(bod_flag_n)
);

// File: tb/tb_brownout_reset_seq.sv
`timescale 1ns/1ps
module tb_brownout_reset_seq;
  localparam int T = 20;
  localparam int Q = 5;

  logic       clk_lf = 1'b0;
  logic       por_in = 1'b1;
  logic       bod_low_in = 1'b0;
  logic       ext_rst_req = 1'b0;
  logic       pwrt_off = 1'b0;
  logic [1:0] bod_mode = 2'b11;
  logic       sw_bod_en = 1'b0;
  logic       sleep_mode = 1'b0;
  logic       por_flag_wr = 1'b0;
  logic       bod_flag_wr = 1'b0;
  logic       rst_out, por_flag_n, bod_flag_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_lf = ~clk_lf;

  brownout_reset_seq #(.PWRT_TICKS(T), .BOD_QUAL(Q)) dut (
    .clk_lf(clk_lf), .por_in(por_in), .bod_low_in(bod_low_in),
    .ext_rst_req(ext_rst_req), .pwrt_off(pwrt_off), .bod_mode(bod_mode),
    .sw_bod_en(sw_bod_en), .sleep_mode(sleep_mode),
    .por_flag_wr(por_flag_wr), .bod_flag_wr(bod_flag_wr),
    .rst_out(rst_out), .por_flag_n(por_flag_n), .bod_flag_n(bod_flag_n)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Number of edges from now until rst_out is seen low.
  task automatic edges_to_release(output int n);
    n = 0;
    do begin
      @(negedge clk_lf);
      n++;
    end while (rst_out && n < 2000);
  endtask

  task automatic settle();
    int n;
    edges_to_release(n);
  endtask

  task automatic dip(int len, bit exp_trip, string req);
    bit saw = 1'b0;
    @(negedge clk_lf);
    bod_low_in = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_lf);
      if (rst_out) saw = 1'b1;
    end
    bod_low_in = 1'b0;
    for (int i = 0; i < Q + 8; i++) begin
      @(negedge clk_lf);
      if (rst_out) saw = 1'b1;
    end
    check(saw == exp_trip, req, int'(saw), int'(exp_trip));
    settle();
  endtask

  task automatic t_por();
    int n;
    por_in = 1'b1;
    pwrt_off = 1'b0;
    repeat (4) @(negedge clk_lf);
    check(rst_out == 1'b1, "R1 reset during power-on", rst_out, 1);
    check(por_flag_n == 1'b0, "R11 por flag after power-on", por_flag_n, 0);
    check(bod_flag_n == 1'b1, "R11 bod flag after power-on", bod_flag_n, 1);
    por_in = 1'b0;
    edges_to_release(n);
    check(n == T + 3, "R2 power-on release edge", n, T + 3);
    // Power-on again with the delay skipped
    @(negedge clk_lf);
    pwrt_off = 1'b1;
    por_in = 1'b1;
    repeat (3) @(negedge clk_lf);
    check(rst_out == 1'b1, "R1 reset on second power-on", rst_out, 1);
    por_in = 1'b0;
    edges_to_release(n);
    check(n == 3, "R3 power-on release without delay", n, 3);
    pwrt_off = 1'b0;
  endtask

  task automatic t_ext();
    int n;
    @(negedge clk_lf);
    ext_rst_req = 1'b1;
    @(negedge clk_lf);
    check(rst_out == 1'b1, "R1 external request asserts reset", rst_out, 1);
    @(negedge clk_lf);
    ext_rst_req = 1'b0;
    edges_to_release(n);
    check(n == T + 1, "R2 external release edge", n, T + 1);
    pwrt_off = 1'b1;
    @(negedge clk_lf);
    ext_rst_req = 1'b1;
    @(negedge clk_lf);
    ext_rst_req = 1'b0;
    edges_to_release(n);
    check(n == 1, "R3 external release without delay", n, 1);
    pwrt_off = 1'b0;
  endtask

  task automatic t_filter();
    bod_mode = 2'b11;
    dip(Q - 1, 1'b0, "R4 dip one edge short");
    dip(Q, 1'b1, "R4 dip at qualification length");
    dip(Q + 3, 1'b1, "R4 long dip");
  endtask

  task automatic t_modes();
    bod_mode = 2'b00; sw_bod_en = 1'b1; sleep_mode = 1'b0;
    dip(3 * Q, 1'b0, "R5 mode 00 disabled");
    bod_mode = 2'b01; sw_bod_en = 1'b0;
    dip(Q + 3, 1'b0, "R6 mode 01 software off");
    sw_bod_en = 1'b1;
    dip(Q + 3, 1'b1, "R6 mode 01 software on");
    bod_mode = 2'b10; sleep_mode = 1'b1; sw_bod_en = 1'b1;
    dip(Q + 3, 1'b0, "R7 mode 10 asleep");
    sleep_mode = 1'b0; sw_bod_en = 1'b0;
    dip(Q + 3, 1'b1, "R7 mode 10 awake, software bit ignored");
    bod_mode = 2'b11; sleep_mode = 1'b1; sw_bod_en = 1'b0;
    dip(Q + 3, 1'b1, "R8 mode 11 asleep");
    sleep_mode = 1'b0;
  endtask

  task automatic t_disable_mid();
    bit saw = 1'b0;
    bod_mode = 2'b01; sw_bod_en = 1'b1;
    @(negedge clk_lf);
    bod_low_in = 1'b1;
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < Q - 2; i++) begin
        @(negedge clk_lf);
        if (rst_out) saw = 1'b1;
      end
      sw_bod_en = 1'b0;
      @(negedge clk_lf);
      if (rst_out) saw = 1'b1;
      sw_bod_en = 1'b1;
    end
    bod_low_in = 1'b0;
    for (int i = 0; i < Q + 6; i++) begin
      @(negedge clk_lf);
      if (rst_out) saw = 1'b1;
    end
    check(saw == 1'b0, "R9 disable clears qualification", int'(saw), 0);
    bod_mode = 2'b11;
  endtask

  task automatic t_restart();
    int n;
    bit fell = 1'b0;
    bod_mode = 2'b11;
    @(negedge clk_lf);
    ext_rst_req = 1'b1;
    @(negedge clk_lf);
    ext_rst_req = 1'b0;
    repeat (T / 2) @(negedge clk_lf);
    bod_low_in = 1'b1;
    for (int i = 0; i < Q + 3; i++) begin
      @(negedge clk_lf);
      if (!rst_out) fell = 1'b1;
    end
    check(fell == 1'b0, "R10 reset held through brown-out in delay", int'(fell), 0);
    bod_low_in = 1'b0;
    edges_to_release(n);
    check(n == T + 4, "R10 full delay after recovery", n, T + 4);
  endtask

  task automatic t_flags();
    @(negedge clk_lf);
    por_flag_wr = 1'b1;
    @(negedge clk_lf);
    por_flag_wr = 1'b0;
    check(por_flag_n == 1'b1, "R11 por flag set by write", por_flag_n, 1);
    check(bod_flag_n == 1'b0, "R11 bod flag after brown-outs", bod_flag_n, 0);
    bod_flag_wr = 1'b1;
    @(negedge clk_lf);
    bod_flag_wr = 1'b0;
    check(bod_flag_n == 1'b1, "R11 bod flag set by write", bod_flag_n, 1);
    dip(Q + 2, 1'b1, "R11 brown-out before flag check");
    check(bod_flag_n == 1'b0, "R11 brown-out clears bod flag", bod_flag_n, 0);
    check(por_flag_n == 1'b1, "R11 brown-out keeps por flag", por_flag_n, 1);
    bod_flag_wr = 1'b1;
    @(negedge clk_lf);
    bod_flag_wr = 1'b0;
    @(negedge clk_lf);
    ext_rst_req = 1'b1;
    @(negedge clk_lf);
    ext_rst_req = 1'b0;
    settle();
    check(por_flag_n == 1'b1 && bod_flag_n == 1'b1, "R11 external reset leaves flags",
          {por_flag_n, bod_flag_n}, 3);
  endtask

  initial begin
    t_por();
    t_ext();
    t_filter();
    t_modes();
    t_disable_mid();
    t_restart();
    t_flags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_lf);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule